// File: doc/BRIEF.md
# Packet Page Allocator and Queues

This block owns a small pool of fixed-size packet pages inside a network controller. It tracks which pages are in use with a bitmap and hands out the lowest free page on request. It keeps three queues of page numbers: pages waiting to be sent, pages whose transmission has finished, and pages holding received frames. Software drives it through a one-byte command register, a packet-number register, an interrupt acknowledge byte and an interrupt mask byte. The frame engines drive it through two strobes: one for a received frame that needs a page, and one for a sent frame.

An allocation that finds no free page is not lost. It stays pending and completes by itself as soon as any page is released. A set of interrupt status bits follows the state of the queues and the allocator. The interrupt request output is high whenever any status bit is enabled in the mask.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocate command takes the lowest-numbered free page, marks it used, places its number in the allocation result byte and sets status bit 3 (allocation done).
- R2: When no page is free, an allocate command clears status bit 3 and sets the result byte to 0x80, and the request stays pending. The next page release (command 5, or command 4 with a non-empty receive queue) completes it: the result byte takes the new page number and bit 3 is set.
- R3: The command is cmd_data[7:5]: 0 no operation, 1 allocate, 2 allocator reset, 3 receive pop, 4 receive pop with release of the head page, 5 release the page in the packet-number register, 6 push the packet-number register onto the transmit queue, 7 transmit queues reset. Command 0 changes no state.
- R4: Allocator reset (command 2) frees every page, empties the transmit, completion and receive queues and cancels a pending allocation.
- R5: Command 6 appends the packet number to the transmit queue, and a push onto a full queue (4 entries) is dropped. tx_sent moves the transmit queue head to the completion queue. Command 7 empties the transmit and completion queues and leaves the receive queue unchanged.
- R6: Status bit 2 (transmit empty) is set whenever the transmit queue is empty and bit 1 (transmit done) whenever the completion queue holds an entry. Both bits stay set until they are acknowledged. After reset the status byte reads 0x04.
- R7: rx_frame takes the lowest free page, appends it to the receive queue and sets status bit 0. rx_ready is low when every page is used, and a frame arriving at that moment is dropped.
- R8: A receive pop removes the queue head and moves the rest forward. Status bit 0 then stays set if entries remain and is cleared otherwise. A pop of an empty queue changes nothing.
- R9: An acknowledge write clears the status bits selected by ack_data AND 0xD6, so bits 0 and 3 cannot be cleared this way. If ack_data bit 1 is set, the write also removes the completion queue head.
- R10: irq is high exactly when some status bit is set and the matching mask bit is also set. The mask is 0x00 after reset.
- R11: done_head and rx_head give the head page number of the completion and receive queues, and read 0x80 when that queue is empty.
- R12: free_pages gives 4 minus the number of used pages. It is registered, so it shows the new value in the cycle after the event that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte, operation in bits 7:5 |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_data | input | 2 | Packet number to store |
| ack_we | input | 1 | Interrupt acknowledge write strobe |
| ack_data | input | 8 | Status bits to acknowledge |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| rx_frame | input | 1 | A received frame requests a page |
| tx_sent | input | 1 | The transmit queue head has been sent |
| rx_ready | output | 1 | At least one page is free |
| alloc_result | output | 8 | Last allocation result, 0x80 on failure |
| free_pages | output | 3 | Number of free pages |
| done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| int_status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the pool and then releases a page while an allocation is pending. A design that drops the pending request leaves the result at 0x80. A design that retries on every cycle would allocate before the release and take the wrong page. The bench pushes a fifth entry onto a full transmit queue and then drains the completion queue through acknowledges. An overflow that is not dropped shows up as an extra head value, or as a head that has been overwritten. It also pops an empty receive queue and acknowledges with 0xFF. These expose a counter that underflows, an allocation-done bit that can be acknowledged away, and transmit-empty or transmit-done bits that are not re-asserted while their queue condition holds.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

  localparam logic [7:0] NO_PAGE  = 8'h80;
  localparam logic [7:0] ACK_MASK = 8'hD6;

  localparam int ST_RCV   = 0;
  localparam int ST_TX    = 1;
  localparam int ST_TXE   = 2;
  localparam int ST_ALLOC = 3;

  localparam logic [7:0] STATUS_RST = 8'h04;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RXPOP   = 3'd3,
    OP_RXFREE  = 3'd4,
    OP_RELEASE = 3'd5,
    OP_TXPUSH  = 3'd6,
    OP_TXRESET = 3'd7
  } op_e;

  // Index of the lowest clear bit among the low n bits, or -1 if all are set.
  function automatic int lowest_free(input logic [31:0] used, input int n);
    int idx;
    idx = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (!used[i]) idx = i;
    end
    return idx;
  endfunction

  // Number of set bits among the low n bits.
  function automatic int count_used(input logic [31:0] used, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (used[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int EW    = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [EW-1:0] slot [DEPTH];
  logic          do_pop, do_push;
  logic [CW-1:0] wr_idx;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign wr_idx  = count - CW'(do_pop);
  assign head    = slot[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam int NXT = (g < DEPTH - 1) ? g + 1 : g;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (!clear) begin
        if (do_push && wr_idx == CW'(g)) slot[g] <= push_data;
        else if (do_pop)                 slot[g] <= slot[NXT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else              count <= count + CW'(do_push) - CW'(do_pop);
  end

  // R8
  pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clear) |=> (count == '0));

  // R5
  push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clear) |=> (count == CW'(DEPTH)));

  // R5
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clear) |=> (count == $past(count) + CW'(1)));

endmodule

// File: rtl/page_bitmap.sv
module page_bitmap
  import pkt_page_pkg::*;
#(
  parameter int N   = 4,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rel_en,
  input  logic [IW-1:0] rel_idx,
  input  logic          alloc_en,
  output logic          grant_ok,
  output logic [IW-1:0] grant_idx,
  output logic          all_used,
  output logic [CW-1:0] free_cnt
);

  logic [N-1:0] bitmap, after_rel, grant_bit, bm_next;

  assign after_rel = bitmap & ~(rel_en ? (N'(1) << rel_idx) : '0);
  assign all_used  = &bitmap;

  always_comb begin
    int slot;
    slot      = lowest_free(32'(after_rel), N);
    grant_ok  = (slot >= 0);
    grant_idx = grant_ok ? IW'(slot) : '0;
  end

  assign grant_bit = (alloc_en && grant_ok) ? (N'(1) << grant_idx) : '0;
  assign bm_next   = clear ? '0 : (after_rel | grant_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitmap   <= '0;
      free_cnt <= CW'(N);
    end else begin
      bitmap   <= bm_next;
      free_cnt <= CW'(N - count_used(32'(bm_next), N));
    end
  end

  // R1
  grant_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && grant_ok && !clear) |=> bitmap[$past(grant_idx)]);

  // R2
  no_grant_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && all_used && !rel_en) |-> !grant_ok);

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = $clog2(NUM_PAGES),
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_data,
  input  logic          pnum_we,
  input  logic [PW-1:0] pnum_data,
  input  logic          ack_we,
  input  logic [7:0]    ack_data,
  input  logic          mask_we,
  input  logic [7:0]    mask_data,
  input  logic          rx_frame,
  input  logic          tx_sent,
  output logic          rx_ready,
  output logic [7:0]    alloc_result,
  output logic [CW-1:0] free_pages,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [7:0]    int_status,
  output logic          irq
);

  localparam int NQ = 3;
  localparam int QT = 0;
  localparam int QD = 1;
  localparam int QR = 2;

  // Event decode, one strobe per cycle, priority cmd > ack > rx > tx.
  op_e  op;
  logic ev_cmd, ev_ack, ev_rx, ev_tx;
  logic op_alloc, op_reset, op_rxpop, op_rxfree, op_release, op_txpush, op_txreset;

  assign op     = op_e'(cmd_data[7:5]);
  assign ev_cmd = cmd_we;
  assign ev_ack = ack_we && !cmd_we;
  assign ev_rx  = rx_frame && !cmd_we && !ack_we;
  assign ev_tx  = tx_sent && !cmd_we && !ack_we && !rx_frame;

  assign op_alloc   = ev_cmd && (op == OP_ALLOC);
  assign op_reset   = ev_cmd && (op == OP_RESET);
  assign op_rxpop   = ev_cmd && (op == OP_RXPOP);
  assign op_rxfree  = ev_cmd && (op == OP_RXFREE);
  assign op_release = ev_cmd && (op == OP_RELEASE);
  assign op_txpush  = ev_cmd && (op == OP_TXPUSH);
  assign op_txreset = ev_cmd && (op == OP_TXRESET);

  logic cmd_unused;
  assign cmd_unused = ^cmd_data[4:0];

  // Plain registers
  logic [PW-1:0] pnum_q;
  logic [7:0]    mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnum_q <= '0;
      mask_q <= '0;
    end else begin
      if (pnum_we) pnum_q <= pnum_data;
      if (mask_we) mask_q <= mask_data;
    end
  end

  // Queues
  logic [NQ-1:0] q_push, q_pop, q_clear, q_empty, q_full;
  logic [PW-1:0] q_din  [NQ];
  logic [PW-1:0] q_head [NQ];
  logic [CW-1:0] q_cnt  [NQ];

  // Allocator wires
  logic          rel_en, alloc_en, grant_ok, all_used, pending_q;
  logic [PW-1:0] rel_idx, grant_idx;
  logic          rx_pop_ok, rx_accept, tx_grant, tx_fail, retry;

  assign rx_pop_ok = (op_rxpop || op_rxfree) && !q_empty[QR];
  assign rel_en    = op_release || (op_rxfree && !q_empty[QR]);
  assign rel_idx   = op_release ? pnum_q : q_head[QR];
  assign retry     = pending_q && rel_en;
  assign alloc_en  = op_alloc || retry || ev_rx;
  assign tx_grant  = (op_alloc || retry) && grant_ok;
  assign tx_fail   = op_alloc && !grant_ok;
  assign rx_accept = ev_rx && grant_ok;

  assign q_push[QT]  = op_txpush;
  assign q_din[QT]   = pnum_q;
  assign q_pop[QT]   = ev_tx;
  assign q_clear[QT] = op_reset || op_txreset;

  assign q_push[QD]  = ev_tx && !q_empty[QT];
  assign q_din[QD]   = q_head[QT];
  assign q_pop[QD]   = ev_ack && ack_data[ST_TX];
  assign q_clear[QD] = op_reset || op_txreset;

  assign q_push[QR]  = rx_accept;
  assign q_din[QR]   = grant_idx;
  assign q_pop[QR]   = op_rxpop || op_rxfree;
  assign q_clear[QR] = op_reset;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    page_queue #(.DEPTH(NUM_PAGES), .EW(PW)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (q_clear[g]),
      .push     (q_push[g]),
      .push_data(q_din[g]),
      .pop      (q_pop[g]),
      .head     (q_head[g]),
      .count    (q_cnt[g]),
      .empty    (q_empty[g]),
      .full     (q_full[g])
    );
  end

  logic q_unused;
  assign q_unused = ^{q_full, q_cnt[QT], q_cnt[QD]};

  page_bitmap #(.N(NUM_PAGES)) u_bitmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (op_reset),
    .rel_en   (rel_en),
    .rel_idx  (rel_idx),
    .alloc_en (alloc_en),
    .grant_ok (grant_ok),
    .grant_idx(grant_idx),
    .all_used (all_used),
    .free_cnt (free_pages)
  );

  assign rx_ready = !all_used;

  // Pending allocation and result byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q    <= 1'b0;
      alloc_result <= NO_PAGE;
    end else begin
      if (op_reset)      pending_q <= 1'b0;
      else if (tx_grant) pending_q <= 1'b0;
      else if (tx_fail)  pending_q <= 1'b1;
      if (tx_grant)      alloc_result <= {{(8-PW){1'b0}}, grant_idx};
      else if (tx_fail)  alloc_result <= NO_PAGE;
    end
  end

  // Status: sticky register plus live queue conditions
  logic [7:0] st_q, st_n, live;
  logic       tx_empty_now, done_any_now;

  assign tx_empty_now = q_empty[QT];
  assign done_any_now = !q_empty[QD];

  always_comb begin
    live         = '0;
    live[ST_TXE] = tx_empty_now;
    live[ST_TX]  = done_any_now;
  end

  always_comb begin
    st_n = st_q | live;
    if (op_alloc)  st_n[ST_ALLOC] = 1'b0;
    if (tx_grant)  st_n[ST_ALLOC] = 1'b1;
    if (rx_pop_ok) st_n[ST_RCV]   = (q_cnt[QR] > CW'(1));
    if (rx_accept) st_n[ST_RCV]   = 1'b1;
    if (ev_ack)    st_n           = st_n & ~(ack_data & ACK_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= STATUS_RST;
    else        st_q <= st_n;
  end

  assign int_status = st_q | live;
  assign irq        = |(int_status & mask_q);
  assign done_head  = q_empty[QD] ? NO_PAGE : {{(8-PW){1'b0}}, q_head[QD]};
  assign rx_head    = q_empty[QR] ? NO_PAGE : {{(8-PW){1'b0}}, q_head[QR]};

  // port rule: at most one event strobe per cycle
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, ack_we, rx_frame, tx_sent}));

  // R2
  fail_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |=> (alloc_result == NO_PAGE) && !int_status[ST_ALLOC]);

  // R2
  retry_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && rel_en) |=> int_status[ST_ALLOC] && (alloc_result != NO_PAGE));

  // R9
  ack_keeps_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (int_status[ST_ALLOC] == $past(int_status[ST_ALLOC])));

  // R7
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && !rx_ready) |=> (q_cnt[QR] == $past(q_cnt[QR])));

endmodule

// File: tb/pkt_page_mgr_tb_top.sv
`timescale 1ns/1ps
module pkt_page_mgr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0, pnum_we = 1'b0, ack_we = 1'b0, mask_we = 1'b0;
  logic       rx_frame = 1'b0, tx_sent = 1'b0;
  logic [7:0] cmd_data = '0, ack_data = '0, mask_data = '0;
  logic [1:0] pnum_data = '0;
  logic       rx_ready, irq;
  logic [7:0] alloc_result, done_head, rx_head, int_status;
  logic [2:0] free_pages;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_page_mgr dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_data(cmd_data),
    .pnum_we(pnum_we), .pnum_data(pnum_data),
    .ack_we(ack_we), .ack_data(ack_data),
    .mask_we(mask_we), .mask_data(mask_data),
    .rx_frame(rx_frame), .tx_sent(tx_sent),
    .rx_ready(rx_ready), .alloc_result(alloc_result),
    .free_pages(free_pages), .done_head(done_head),
    .rx_head(rx_head), .int_status(int_status), .irq(irq)
  );

  localparam int S_RES = 0, S_FREE = 1, S_DONE = 2, S_RX = 3,
                 S_STAT = 4, S_IRQ = 5, S_RDY = 6;

  typedef struct {
    string req;
    int    sel;
    int    val;
  } exp_t;

  exp_t sb[$];

  function automatic int observe(input int sel);
    case (sel)
      S_RES:   return int'(alloc_result);
      S_FREE:  return int'(free_pages);
      S_DONE:  return int'(done_head);
      S_RX:    return int'(rx_head);
      S_STAT:  return int'(int_status);
      S_IRQ:   return int'(irq);
      default: return int'(rx_ready);
    endcase
  endfunction

  function automatic string sel_name(input int sel);
    case (sel)
      S_RES:   return "alloc_result";
      S_FREE:  return "free_pages";
      S_DONE:  return "done_head";
      S_RX:    return "rx_head";
      S_STAT:  return "int_status";
      S_IRQ:   return "irq";
      default: return "rx_ready";
    endcase
  endfunction

  task automatic ex(input string req, input int sel, input int val);
    exp_t e;
    e.req = req; e.sel = sel; e.val = val;
    sb.push_back(e);
  endtask

  // Monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        int   act;
        e = sb.pop_front();
        act = observe(e.sel);
        checks++;
        if (act != e.val) begin
          errors++;
          $display("FAIL %s %s actual %0h expected %0h", e.req, sel_name(e.sel), act, e.val);
        end
      end
    end
  end

  localparam int K_CMD = 0, K_ACK = 1, K_MASK = 2, K_PNUM = 3, K_RX = 4, K_TX = 5;

  task automatic strobe(input int kind, input logic [7:0] d);
    @(negedge clk);
    case (kind)
      K_CMD:   begin cmd_we = 1'b1;  cmd_data = d;       end
      K_ACK:   begin ack_we = 1'b1;  ack_data = d;       end
      K_MASK:  begin mask_we = 1'b1; mask_data = d;      end
      K_PNUM:  begin pnum_we = 1'b1; pnum_data = d[1:0]; end
      K_RX:    rx_frame = 1'b1;
      default: tx_sent = 1'b1;
    endcase
    @(negedge clk);
    cmd_we = 1'b0; ack_we = 1'b0; mask_we = 1'b0; pnum_we = 1'b0;
    rx_frame = 1'b0; tx_sent = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);   strobe(K_CMD, d);  endtask
  task automatic ack(input logic [7:0] d);   strobe(K_ACK, d);  endtask
  task automatic mask(input logic [7:0] d);  strobe(K_MASK, d); endtask
  task automatic txpush(input logic [7:0] p); strobe(K_PNUM, p); cmd(8'hC0); endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    ex("R6", S_STAT, 'h04); ex("R2", S_RES, 'h80); ex("R12", S_FREE, 4);
    ex("R11", S_DONE, 'h80); ex("R11", S_RX, 'h80); ex("R10", S_IRQ, 0);
    ex("R7", S_RDY, 1);

    mask(8'h04); ex("R10", S_IRQ, 1);
    mask(8'h00); ex("R10", S_IRQ, 0);

    // R1: lowest free page, in order
    cmd(8'h20); ex("R1", S_RES, 0); ex("R1", S_STAT, 'h0C); ex("R12", S_FREE, 3);
    cmd(8'h20); ex("R1", S_RES, 1); ex("R12", S_FREE, 2);
    cmd(8'h20); ex("R1", S_RES, 2);
    cmd(8'h20); ex("R1", S_RES, 3); ex("R12", S_FREE, 0); ex("R7", S_RDY, 0);

    // R2: failure, then retry on release
    cmd(8'h20); ex("R2", S_RES, 'h80); ex("R2", S_STAT, 'h04);
    strobe(K_PNUM, 8'd2);
    cmd(8'hA0); ex("R2", S_RES, 2); ex("R2", S_STAT, 'h0C); ex("R2", S_FREE, 0);

    // R5/R6: transmit queue, sticky empty bit
    txpush(8'd1); ex("R6", S_STAT, 'h0C);
    ack(8'h04); ex("R9", S_STAT, 'h08);
    txpush(8'd3); txpush(8'd0); txpush(8'd2);
    txpush(8'd1); // fifth push onto a full queue is dropped
    strobe(K_TX, 8'd0); ex("R5", S_DONE, 1); ex("R6", S_STAT, 'h0A);
    strobe(K_TX, 8'd0); strobe(K_TX, 8'd0); strobe(K_TX, 8'd0);
    ex("R6", S_STAT, 'h0E);
    strobe(K_TX, 8'd0); ex("R5", S_DONE, 1);

    // R9: acknowledge pops completion queue
    ack(8'h02); ex("R9", S_DONE, 3); ex("R6", S_STAT, 'h0E);
    ack(8'h02); ex("R9", S_DONE, 0);
    ack(8'h02); ex("R9", S_DONE, 2);
    ack(8'h02); ex("R5", S_DONE, 'h80); ex("R9", S_STAT, 'h0C);
    ack(8'hFF); ex("R9", S_STAT, 'h0C);

    mask(8'h08); ex("R10", S_IRQ, 1);
    mask(8'h10); ex("R10", S_IRQ, 0);
    mask(8'h00);

    // R3: no-operation command
    cmd(8'h1F); ex("R3", S_RES, 2); ex("R3", S_FREE, 0); ex("R3", S_STAT, 'h0C);

    // R4: allocator reset
    cmd(8'h40); ex("R4", S_FREE, 4); ex("R4", S_RDY, 1);

    // R7/R8: receive path
    strobe(K_RX, 8'd0); ex("R7", S_RX, 0); ex("R7", S_STAT, 'h0D); ex("R12", S_FREE, 3);
    strobe(K_RX, 8'd0); strobe(K_RX, 8'd0); ex("R7", S_FREE, 1); ex("R7", S_RX, 0);
    cmd(8'h60); ex("R8", S_RX, 1); ex("R8", S_STAT, 'h0D); ex("R8", S_FREE, 1);
    cmd(8'h80); ex("R8", S_RX, 2); ex("R8", S_FREE, 2);
    cmd(8'h60); ex("R8", S_RX, 'h80); ex("R8", S_STAT, 'h0C);
    cmd(8'h60); ex("R8", S_RX, 'h80); ex("R8", S_STAT, 'h0C); ex("R8", S_FREE, 2);
    strobe(K_RX, 8'd0); ex("R7", S_RX, 1); ex("R7", S_FREE, 1);

    // R4: reset empties every queue
    txpush(8'd0); strobe(K_TX, 8'd0); ex("R5", S_DONE, 0);
    txpush(8'd1);
    cmd(8'h40); ex("R4", S_DONE, 'h80); ex("R4", S_RX, 'h80); ex("R4", S_FREE, 4);
    strobe(K_TX, 8'd0); ex("R4", S_DONE, 'h80);

    // R5: transmit queues reset leaves receive queue
    txpush(8'd2); strobe(K_TX, 8'd0); ex("R5", S_DONE, 2);
    txpush(8'd3);
    strobe(K_RX, 8'd0); ex("R7", S_RX, 0);
    cmd(8'hE0); ex("R5", S_DONE, 'h80); ex("R5", S_RX, 0);
    strobe(K_TX, 8'd0); ex("R5", S_DONE, 'h80);

    // R2/R7: pool full, frame dropped, retry via pop-and-release
    strobe(K_RX, 8'd0); strobe(K_RX, 8'd0); strobe(K_RX, 8'd0);
    ex("R7", S_FREE, 0); ex("R7", S_RDY, 0);
    strobe(K_RX, 8'd0); ex("R7", S_FREE, 0); ex("R7", S_RX, 0);
    cmd(8'h20); ex("R2", S_RES, 'h80);
    cmd(8'h80); ex("R2", S_RES, 0); ex("R8", S_RX, 1); ex("R2", S_FREE, 0);
    mask(8'h08); ex("R2", S_IRQ, 1);
    mask(8'h01); ex("R8", S_IRQ, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule